// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block produces the two DMA request lines for one serial channel: one that asks the host to fill a 64-byte transmit FIFO, and one that asks the host to empty the receive FIFO. Both strobes from the host bus are active low and already synchronous to the block clock. The block detects each falling edge by comparing the present sample with the one taken a cycle earlier. Every detected falling edge that occurs while a request is up moves exactly one byte.

Before a transmit transfer, the host stages the upper byte of a 16-bit byte count and then writes the lower byte, which commits the count. The block splits the count into full 64-byte blocks followed by one shorter block that carries the remainder. It raises the transmit request only when the FIFO has room for the whole next block. When the count runs out, a one-clock done pulse is given, and the request stays quiet until a new count is committed.

On receive, a 3-bit selector chooses a block of 64, 32, 16, 8 or 4 bytes. The receive request rises once the FIFO fill level covers one block. Each request stays high until the last byte of its block has moved, and it drops on the clock edge that samples the falling edge of that byte's strobe.

Top module: `fifo_dma_req`

## Requirements
- R1: While reset is held, and after it is released with no further stimulus, `tx_req`, `rx_req` and `tx_done` are all low.
- R2: A pulse on `cnt_hi_we` only stages `cnt_data` as the upper count byte. A pulse on `cnt_lo_we` commits the count {staged upper, `cnt_data`}, abandons any transmit block in progress, and arms the transmitter. A committed count of 0 never raises `tx_req`.
- R3: The next transmit block is 64 bytes while the remaining count is at least 64, and otherwise equals the remaining count. `tx_req` rises only when `tx_space` is at least that block length.
- R4: A falling edge of `wr_n` is a sample at 0 that follows a sample at 1. Each such edge while `tx_req` is high moves one byte, and `tx_req` stays high until the block's last byte. On the clock edge that samples the falling edge of that last byte, `tx_req` goes low.
- R5: Falling edges of `wr_n` while `tx_req` is low do not change the remaining count. A `wr_n` held low for several cycles counts as one byte.
- R6: `tx_done` is high for exactly one clock, in the cycle where the final block's request drops. After that, `tx_req` stays low whatever `tx_space` is, until the next `cnt_lo_we`.
- R7: `rx_size_sel` values 0, 1, 2, 3 and 4 select receive blocks of 64, 32, 16, 8 and 4 bytes. Values 5 to 7 select 64.
- R8: `rx_req` rises once `rx_level` is at least the block size, and stays high until that many falling edges of `rd_n` have been seen. It is low in the cycle after the edge that samples the last one. Read strobes while `rx_req` is low are ignored, and a held-low `rd_n` counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_n | input | 1 | Host write strobe, active low, synchronous |
| rd_n | input | 1 | Host read strobe, active low, synchronous |
| cnt_hi_we | input | 1 | Stage upper count byte from `cnt_data` |
| cnt_lo_we | input | 1 | Commit count with lower byte from `cnt_data` |
| cnt_data | input | 8 | Count byte written by the host |
| tx_space | input | 7 | Free bytes in the transmit FIFO (0 to 64) |
| rx_size_sel | input | 3 | Receive block size selector |
| rx_level | input | 7 | Filled bytes in the receive FIFO (0 to 64) |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_done | output | 1 | One-clock pulse when the transmit count is used up |

## Verification
On every cycle, the bound checker confirms four things. Either request falls only right after a detected strobe edge or a count commit. A request rises only when the FIFO space or fill level covered the block. `tx_done` is a lone pulse with the count at zero and no request. Only the bench's scenarios show the exact byte accounting: a 64-byte block followed by a remainder, the use of the upper count byte, strobes that are ignored or held low, a commit that cuts a block short, and the full decode of the receive block size.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;
  localparam int unsigned RX_SEL_W   = 3;
  localparam int unsigned RX_N_SIZES = 5;

  typedef logic [RX_SEL_W-1:0] rx_sel_t;

  // Block length for a receive selector: depth halved per step, out-of-range codes give full depth
  function automatic int unsigned rx_block_len(input rx_sel_t sel, input int unsigned depth);
    if (int'(sel) < RX_N_SIZES) return depth >> sel;
    return depth;
  endfunction
endpackage

// File: rtl/fdr_rst_sync.sv
module fdr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fdr_fall_det.sv
module fdr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strb_n;
  end

  assign fall = prev_q & ~strb_n;
endmodule

// File: rtl/fdr_tx_seq.sv
module fdr_tx_seq #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned HI_W  = CNT_W - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_hi_we,
  input  logic             cnt_lo_we,
  input  logic [7:0]       cnt_data,
  input  logic             wr_fall,
  input  logic [LVL_W-1:0] tx_space,
  output logic             tx_req,
  output logic             tx_done,
  output logic [CNT_W-1:0] remain
);
  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             armed_q, armed_d;
  logic             act_q, act_d;
  logic [LVL_W-1:0] len_q, prog_q, prog_d, prog_inc, next_len;
  logic             done_q, done_d;
  logic             start, step, blk_end, len_en;

  assign next_len = (remain_q >= CNT_W'(DEPTH)) ? LVL_W'(DEPTH) : remain_q[LVL_W-1:0];
  assign prog_inc = prog_q + LVL_W'(1);
  assign start    = armed_q & ~act_q & (remain_q != '0) & (tx_space >= next_len);
  assign step     = act_q & wr_fall;
  assign blk_end  = step & (prog_inc == len_q);
  assign len_en   = start & ~cnt_lo_we;

  always_comb begin
    remain_d = remain_q;
    armed_d  = armed_q;
    act_d    = act_q;
    prog_d   = prog_q;
    done_d   = 1'b0;
    if (cnt_lo_we) begin
      remain_d = {hi_q, cnt_data};
      armed_d  = 1'b1;
      act_d    = 1'b0;
      prog_d   = '0;
    end else if (step) begin
      remain_d = remain_q - CNT_W'(1);
      prog_d   = blk_end ? '0 : prog_inc;
      if (blk_end) act_d = 1'b0;
      if (remain_q == CNT_W'(1)) begin
        done_d  = 1'b1;
        armed_d = 1'b0;
        act_d   = 1'b0;
      end
    end else if (start) begin
      act_d  = 1'b1;
      prog_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      remain_q <= '0;
      armed_q  <= 1'b0;
      act_q    <= 1'b0;
      len_q    <= '0;
      prog_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      if (cnt_hi_we) hi_q  <= cnt_data[HI_W-1:0];
      if (len_en)    len_q <= next_len;
      remain_q <= remain_d;
      armed_q  <= armed_d;
      act_q    <= act_d;
      prog_q   <= prog_d;
      done_q   <= done_d;
    end
  end

  assign tx_req  = act_q;
  assign tx_done = done_q;
  assign remain  = remain_q;
endmodule

// File: rtl/fdr_rx_seq.sv
module fdr_rx_seq
  import fifo_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rx_sel_t          rx_size_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rd_fall,
  output logic             rx_req
);
  logic [LVL_W-1:0] size, len_q, prog_q, prog_d, prog_inc;
  logic             act_q, act_d;
  logic             start, step, blk_end;

  assign size     = LVL_W'(rx_block_len(rx_size_sel, DEPTH));
  assign prog_inc = prog_q + LVL_W'(1);
  assign start    = ~act_q & (rx_level >= size);
  assign step     = act_q & rd_fall;
  assign blk_end  = step & (prog_inc == len_q);

  always_comb begin
    act_d  = act_q;
    prog_d = prog_q;
    if (step) begin
      prog_d = blk_end ? '0 : prog_inc;
      if (blk_end) act_d = 1'b0;
    end else if (start) begin
      act_d  = 1'b1;
      prog_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      len_q  <= '0;
      prog_q <= '0;
    end else begin
      if (start) len_q <= size;
      act_q  <= act_d;
      prog_q <= prog_d;
    end
  end

  assign rx_req = act_q;
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
  import fifo_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             cnt_hi_we,
  input  logic             cnt_lo_we,
  input  logic [7:0]       cnt_data,
  input  logic [LVL_W-1:0] tx_space,
  input  logic [2:0]       rx_size_sel,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_req,
  output logic             rx_req,
  output logic             tx_done
);
  logic             rst_sync_n;
  logic [1:0]       strb_n;
  logic [1:0]       strb_fall;
  logic             wr_fall, rd_fall;
  logic [CNT_W-1:0] tx_remain;

  fdr_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  assign strb_n = {rd_n, wr_n};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    fdr_fall_det i_det (
      .clk(clk), .rst_n(rst_sync_n), .strb_n(strb_n[g]), .fall(strb_fall[g])
    );
  end

  assign wr_fall = strb_fall[0];
  assign rd_fall = strb_fall[1];

  fdr_tx_seq #(.CNT_W(CNT_W), .DEPTH(DEPTH)) i_tx (
    .clk(clk), .rst_n(rst_sync_n),
    .cnt_hi_we(cnt_hi_we), .cnt_lo_we(cnt_lo_we), .cnt_data(cnt_data),
    .wr_fall(wr_fall), .tx_space(tx_space),
    .tx_req(tx_req), .tx_done(tx_done), .remain(tx_remain)
  );

  fdr_rx_seq #(.DEPTH(DEPTH)) i_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .rx_size_sel(rx_size_sel), .rx_level(rx_level),
    .rd_fall(rd_fall), .rx_req(rx_req)
  );
endmodule

// File: rtl/fifo_dma_req_chk.sv
module fifo_dma_req_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_fall,
  input logic             rd_fall,
  input logic             cnt_lo_we,
  input logic [LVL_W-1:0] tx_space,
  input logic [LVL_W-1:0] rx_level,
  input logic [2:0]       rx_size_sel,
  input logic [CNT_W-1:0] tx_remain,
  input logic             tx_req,
  input logic             rx_req,
  input logic             tx_done
);
  int tx_need, rx_need;

  always_comb begin
    tx_need = (int'(tx_remain) >= int'(DEPTH)) ? int'(DEPTH) : int'(tx_remain);
    case (rx_size_sel)
      3'd1:    rx_need = int'(DEPTH) / 2;
      3'd2:    rx_need = int'(DEPTH) / 4;
      3'd3:    rx_need = int'(DEPTH) / 8;
      3'd4:    rx_need = int'(DEPTH) / 16;
      default: rx_need = int'(DEPTH);
    endcase
  end

  // R3
  tx_rise_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(int'(tx_space) >= tx_need));
  // R4
  tx_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req) |-> $past(wr_fall || cnt_lo_we));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  // R6
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (tx_remain == '0) && !tx_req);
  // R7
  rx_rise_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> $past(int'(rx_level) >= rx_need));
  // R8
  rx_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_req) |-> $past(rd_fall));
endmodule

bind fifo_dma_req fifo_dma_req_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_fall(wr_fall), .rd_fall(rd_fall),
  .cnt_lo_we(cnt_lo_we), .tx_space(tx_space), .rx_level(rx_level),
  .rx_size_sel(rx_size_sel), .tx_remain(tx_remain),
  .tx_req(tx_req), .rx_req(rx_req), .tx_done(tx_done)
);

// File: tb/test_fifo_dma_req.sv
module test_fifo_dma_req;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, wr_n, rd_n, cnt_hi_we, cnt_lo_we;
  logic [7:0] cnt_data;
  logic [6:0] tx_space, rx_level;
  logic [2:0] rx_size_sel;
  logic       tx_req, rx_req, tx_done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  // selector in [9:7], expected receive block in [6:0] (R7)
  localparam logic [9:0] RX_VEC [0:7] = '{
    {3'd0, 7'd64}, {3'd1, 7'd32}, {3'd2, 7'd16}, {3'd3, 7'd8},
    {3'd4, 7'd4},  {3'd5, 7'd64}, {3'd6, 7'd64}, {3'd7, 7'd64}
  };

  fifo_dma_req i_fifo_dma_req (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .cnt_hi_we(cnt_hi_we), .cnt_lo_we(cnt_lo_we), .cnt_data(cnt_data),
    .tx_space(tx_space), .rx_size_sel(rx_size_sel), .rx_level(rx_level),
    .tx_req(tx_req), .rx_req(rx_req), .tx_done(tx_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    @(negedge clk) wr_n = 1'b0;
    @(negedge clk) wr_n = 1'b1;
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) rd_n = 1'b1;
  endtask

  task automatic load_cnt(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk) begin cnt_hi_we = 1'b1; cnt_data = hi; end
    @(negedge clk) begin cnt_hi_we = 1'b0; cnt_lo_we = 1'b1; cnt_data = lo; end
    @(negedge clk) cnt_lo_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; cnt_hi_we = 1'b0; cnt_lo_we = 1'b0;
    cnt_data = '0; tx_space = 7'd63; rx_size_sel = 3'd0; rx_level = '0;
    tick(3);
    chk("R1 tx_req in reset", tx_req, 1'b0);
    chk("R1 rx_req in reset", rx_req, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 tx_req after reset", tx_req, 1'b0);
    chk("R1 tx_done after reset", tx_done, 1'b0);

    // receive table walk (R7, R8)
    for (int v = 0; v < 8; v++) begin
      int sz;
      sz = int'(RX_VEC[v][6:0]);
      rx_size_sel = RX_VEC[v][9:7];
      rx_level = 7'(sz - 1);
      tick(3);
      chk("R7 below block no rx_req", rx_req, 1'b0);
      rx_level = 7'(sz);
      tick(1);
      chk("R7 full block rx_req", rx_req, 1'b1);
      for (int i = 0; i < sz; i++) begin
        pulse_rd();
        if (i == sz - 2) chk("R8 rx_req held in block", rx_req, 1'b1);
        if (i == sz - 1) begin
          chk("R8 rx_req drops at last read", rx_req, 1'b0);
          rx_level = '0;
        end
      end
      tick(2);
    end

    // R8: reads while idle ignored, held-low read counts once
    rx_size_sel = 3'd4;
    pulse_rd(); pulse_rd();
    rx_level = 7'd4;
    tick(1);
    chk("R8 rx_req up", rx_req, 1'b1);
    @(negedge clk) rd_n = 1'b0;
    tick(4);
    rd_n = 1'b1;
    pulse_rd(); pulse_rd();
    chk("R8 idle and held reads counted once", rx_req, 1'b1);
    pulse_rd();
    chk("R8 drop after fourth edge", rx_req, 1'b0);
    rx_level = '0;

    // R2: zero count
    tx_space = 7'd64;
    load_cnt(8'd0, 8'd0);
    tick(3);
    chk("R2 zero count no tx_req", tx_req, 1'b0);

    // R3: 70 bytes, room check against 64
    tx_space = 7'd63;
    load_cnt(8'd0, 8'd70);
    tick(3);
    chk("R3 63 free rejects 64 block", tx_req, 1'b0);
    tx_space = 7'd64;
    tick(1);
    chk("R3 64 free raises tx_req", tx_req, 1'b1);
    for (int i = 0; i < 64; i++) begin
      pulse_wr();
      if (i == 62) chk("R4 tx_req held in block", tx_req, 1'b1);
    end
    chk("R4 drop after 64th byte", tx_req, 1'b0);
    chk("R6 no done mid count", tx_done, 1'b0);
    tx_space = 7'd5;
    tick(3);
    chk("R3 5 free rejects 6 remainder", tx_req, 1'b0);
    pulse_wr(); pulse_wr(); pulse_wr();
    tx_space = 7'd6;
    tick(2);
    chk("R3 6 free raises remainder block", tx_req, 1'b1);
    for (int i = 0; i < 5; i++) pulse_wr();
    chk("R5 idle writes ignored, done waits", tx_done, 1'b0);
    pulse_wr();
    chk("R6 done on final byte", tx_done, 1'b1);
    chk("R6 tx_req low with done", tx_req, 1'b0);
    tick(1);
    chk("R6 done single cycle", tx_done, 1'b0);
    tx_space = 7'd64;
    tick(3);
    chk("R6 stays low after done", tx_req, 1'b0);

    // R2: commit mid-block abandons block
    load_cnt(8'd0, 8'd10);
    tick(1);
    chk("R2 tx_req for 10", tx_req, 1'b1);
    pulse_wr(); pulse_wr(); pulse_wr();
    load_cnt(8'd0, 8'd2);
    chk("R2 commit drops block", tx_req, 1'b0);
    tick(1);
    chk("R2 new count restarts", tx_req, 1'b1);
    pulse_wr();
    chk("R2 no done after 1 of 2", tx_done, 1'b0);
    pulse_wr();
    chk("R2 done after 2 of 2", tx_done, 1'b1);

    // R5: held-low write counts once
    load_cnt(8'd0, 8'd4);
    tick(1);
    @(negedge clk) wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    pulse_wr(); pulse_wr();
    chk("R5 held write counted once", tx_done, 1'b0);
    pulse_wr();
    chk("R5 done after four edges", tx_done, 1'b1);

    // R2: upper byte used, 0x0102 = 258 bytes
    load_cnt(8'h01, 8'h02);
    tick(1);
    for (int i = 0; i < 258; i++) begin
      pulse_wr();
      if (i == 63) begin
        chk("R4 block boundary drop", tx_req, 1'b0);
        tick(1);
        chk("R3 next block re-raises", tx_req, 1'b1);
      end
      if (i == 256) chk("R2 no done at 257", tx_done, 1'b0);
    end
    chk("R2 done at 258 using upper byte", tx_done, 1'b1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule